// File: doc/BRIEF.md
# Serial ADC Output Port Emulator

This block models the digital side of a delta-sigma converter's three-wire serial output, for use as a stand-in during verification or when emulating the converter in programmable logic. A conversion timer counts ticks of an oscillator enable. When the timer expires, the block captures a supplied signed sample, turns it into a 24-bit frame of four status bits and twenty data bits, and goes to sleep. A host wakes it by pulling chip select low, then clocks the frame out MSB first.

The serial clock is supplied by the host (external mode) or generated by the block at one eighth of the oscillator rate (internal mode). The mode is taken from the serial clock level when reset is released and again at every falling edge of chip select. Reading the last bit, or raising chip select during the transfer, starts the next conversion. All inputs are synchronous to `clk`. The tri-state pins are modelled as data plus enable pairs.

Top module: `adc_port_emu`

## Requirements
- R1: A conversion lasts exactly CONV_CYCLES asserted `osc_tick` cycles, counted from the cycle after the conversion starts up to and including the tick that ends it.
- R2: After a conversion the block sleeps while `cs_n` is high, keeping its result and not starting another conversion. When `cs_n` goes low it shows the ready state at once.
- R3: While `cs_n` is high, `sdo_oe` is 0 and falling edges on `sck_in` have no effect. A later read still begins at frame bit 23.
- R4: With `cs_n` low outside the data phase, `sdo` shows end-of-conversion: 1 while converting and 0 once the result is ready. Right after reset the block is converting.
- R5: The frame is sent MSB first. Bit 23 is on `sdo` when the data phase begins, and each serial clock falling edge moves to the next lower bit. The 24th falling edge drives `sdo` to 1 and starts a new conversion.
- R6: A rise of `cs_n` during the data phase ends the transfer and starts a new conversion immediately.
- R7: If `sck_in` is high at the falling edge of `cs_n`, the block selects internal mode. In internal mode it drives `sck_out` with `sck_oe` = 1 during the data phase only, with a period of SCK_DIV ticks and half that period high. If `sck_in` is low at that edge, the block selects external mode and keeps `sck_oe` at 0.
- R8: Serial clock falling edges after the last data bit read as 1 on `sdo`.
- R9: `sample_in` is captured on the tick that ends the conversion. Later changes to it do not alter the frame being read.
- R10: Frame layout: bit 23 = 0 (end of conversion), bit 22 = 0, bit 21 = sign (1 when the clamped sample is 0 or more), bit 20 = range flag (1 when the clamped sample is below 0 or at least FS = 2^DATA_W). Bits 19..0 are the low DATA_W bits of the clamped sample in two's complement.
- R11: The sample is clamped to the interval from -FS/8 to FS + FS/8 - 1.
- R12: The clock mode in force after reset is the `sck_in` level at reset. Holding `cs_n` low through reset does not count as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cs_n | input | 1 | Active-low chip select |
| sck_in | input | 1 | Serial clock level seen on the pin |
| sample_in | input | DATA_W+2 | Signed sample to convert |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for the serial data pin |
| sck_out | output | 1 | Generated serial clock in internal mode |
| sck_oe | output | 1 | Drive enable for the serial clock pin |

## Verification
The bench aims at the edges of the clamp window and of the range flag: -FS/8 and one below it, -1, 0, FS-1, FS, and the top limit and one above it. A wrong comparison there would flip the sign or range bit, or pass an unclamped code into the data field. It aborts one transfer in internal mode and one part-way through an external read. It checks that end-of-conversion rises straight away; a design that went back to sleep instead would show 0. It clocks the serial line while deselected and changes the sample after the result is captured; a design that took those edges into account would send a frame shifted by a few bits or carrying the new sample. It also measures the conversion in ticks and the generated clock period, which catches off-by-one errors in the counters.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    localparam int STATUS_W = 4;

    typedef enum logic [1:0] {
        PH_CONV  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CYCLES = 20480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && tick && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = done ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic sck,
    output logic fall
);
    localparam int HALF = DIV / 2;
    localparam int HW   = $clog2(HALF + 1);
    localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          sck;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d  = g_q;
        fall = run && tick && (g_q.cnt == HLAST) && g_q.sck;
        if (!run) begin
            g_d.cnt = '0;
            g_d.sck = 1'b0;
        end else if (tick) begin
            if (g_q.cnt == HLAST) begin
                g_d.cnt = '0;
                g_d.sck = ~g_q.sck;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{cnt: '0, sck: 1'b0};
        else        g_q <= g_d;
    end

    assign sck = g_q.sck;

    // R7
    sck_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (g_q.sck == $past(g_q.sck)) || !g_q.sck);

endmodule

// File: rtl/adc_status_fmt.sv
module adc_status_fmt #(
    parameter int DATA_W = 20
) (
    input  logic signed [DATA_W+1:0] sample,
    output logic [DATA_W+adc_emu_pkg::STATUS_W-1:0] frame
);
    localparam int IN_W = DATA_W + 2;
    localparam int FS   = 1 << DATA_W;
    localparam logic signed [IN_W-1:0] LO_S = IN_W'(-(FS / 8));
    localparam logic signed [IN_W-1:0] HI_S = IN_W'(FS + FS / 8 - 1);
    localparam logic signed [IN_W-1:0] FS_S = IN_W'(FS);

    logic signed [IN_W-1:0] clamped;
    logic                   sign_bit;
    logic                   range_bit;

    always_comb begin
        if (sample < LO_S)      clamped = LO_S;
        else if (sample > HI_S) clamped = HI_S;
        else                    clamped = sample;
        sign_bit  = !clamped[IN_W-1];
        range_bit = clamped[IN_W-1] || (clamped >= FS_S);
        frame     = {1'b0, 1'b0, sign_bit, range_bit, clamped[DATA_W-1:0]};
    end

endmodule

// File: rtl/adc_port_emu.sv
module adc_port_emu
    import adc_emu_pkg::*;
#(
    parameter int DATA_W      = 20,
    parameter int CONV_CYCLES = 20480,
    parameter int SCK_DIV     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     osc_tick,
    input  logic                     cs_n,
    input  logic                     sck_in,
    input  logic signed [DATA_W+1:0] sample_in,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic                     sck_out,
    output logic                     sck_oe
);
    localparam int FRAME_W = DATA_W + STATUS_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
        logic               int_mode;
        logic               cs_prev;
        logic               sck_prev;
    } port_t;

    port_t st_d, st_q;

    logic               conv_done;
    logic               int_sck;
    logic               int_fall;
    logic               gen_run;
    logic [FRAME_W-1:0] new_frame;
    logic               cs_fall;
    logic               ext_fall;
    logic               shift;

    adc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.phase == PH_CONV),
        .tick  (osc_tick),
        .done  (conv_done)
    );

    assign gen_run = (st_q.phase == PH_DATA) && st_q.int_mode && !cs_n;

    adc_sck_gen #(.DIV(SCK_DIV)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gen_run),
        .tick  (osc_tick),
        .sck   (int_sck),
        .fall  (int_fall)
    );

    adc_status_fmt #(.DATA_W(DATA_W)) u_fmt (
        .sample (sample_in),
        .frame  (new_frame)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cs_prev  = cs_n;
        st_d.sck_prev = sck_in;
        cs_fall       = st_q.cs_prev && !cs_n;
        ext_fall      = !st_q.int_mode && st_q.sck_prev && !sck_in && !cs_n;
        shift         = (st_q.phase == PH_DATA) && (st_q.int_mode ? int_fall : ext_fall);
        if (cs_fall) st_d.int_mode = sck_in;

        unique case (st_q.phase)
            PH_CONV: begin
                if (conv_done) begin
                    st_d.frame = new_frame;
                    st_d.phase = PH_SLEEP;
                end
            end
            PH_SLEEP: begin
                if (!cs_n) begin
                    st_d.phase = PH_DATA;
                    st_d.idx   = TOP_IDX;
                end
            end
            PH_DATA: begin
                if (cs_n) begin
                    st_d.phase = PH_CONV;
                end else if (shift) begin
                    if (st_q.idx == '0) st_d.phase = PH_CONV;
                    else                st_d.idx   = st_q.idx - 1'b1;
                end
            end
            default: st_d.phase = PH_CONV;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_CONV, idx: '0, frame: '0,
                      int_mode: sck_in, cs_prev: cs_n, sck_prev: sck_in};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.phase)
            PH_SLEEP: sdo = 1'b0;
            PH_DATA:  sdo = st_q.frame[st_q.idx];
            default:  sdo = 1'b1;
        endcase
    end

    assign sdo_oe  = !cs_n;
    assign sck_oe  = gen_run;
    assign sck_out = int_sck;

    // R2
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SLEEP && cs_n) |=> (st_q.phase == PH_SLEEP));

    // R6
    abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA && cs_n) |=> (st_q.phase == PH_CONV));

    // R5
    last_bit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA && !cs_n && shift && st_q.idx == '0) |=> (st_q.phase == PH_CONV && sdo));

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA) |=> $stable(st_q.frame));

endmodule

// File: tb/sim_adc_port_emu.sv
module sim_adc_port_emu;
    localparam int DATA_W = 20;
    localparam int CONV   = 64;
    localparam int DIV    = 8;
    localparam int TICKP  = 3;
    localparam int FS     = 1 << DATA_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic cs_n = 1'b0;
    logic sck_in = 1'b1;
    logic signed [DATA_W+1:0] sample_in = '0;
    logic sdo, sdo_oe, sck_out, sck_oe;

    int checks = 0;
    int errors = 0;
    int tick_seen = 0;
    int ph = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        ph       <= (ph == TICKP - 1) ? 0 : ph + 1;
        osc_tick <= (ph == 0);
    end

    always @(posedge clk) if (osc_tick) tick_seen <= tick_seen + 1;

    adc_port_emu #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .SCK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cs_n(cs_n), .sck_in(sck_in),
        .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .sck_out(sck_out), .sck_oe(sck_oe)
    );

    function automatic logic [23:0] exp_frame(input logic signed [DATA_W+1:0] v);
        int c = int'(v);
        logic s, r;
        if (c < -(FS / 8)) c = -(FS / 8);
        if (c > FS + FS / 8 - 1) c = FS + FS / 8 - 1;
        s = (c >= 0);
        r = (c < 0) || (c >= FS);
        return {2'b00, s, r, c[DATA_W-1:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_eoc(output int ticks_at);
        int guard = 0;
        @(negedge clk);
        while (!(sdo_oe && sdo == 1'b0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 5000) check("R4 eoc timeout", 0, 1);
        ticks_at = tick_seen;
    endtask

    task automatic sck_pulse();
        sck_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sck_in = 1'b0;
        @(negedge clk);
    endtask

    // sdo is sampled after each falling edge; returns the last sampled level
    task automatic read_ext(input int nfalls, output logic [23:0] f, output logic last);
        f = '1;
        f[23] = sdo;
        last = sdo;
        for (int k = 1; k <= nfalls; k++) begin
            sck_pulse();
            if (k <= 23) f[23-k] = sdo;
            last = sdo;
        end
    endtask

    task automatic read_int(output logic [23:0] f, output int period);
        int got = 0;
        int guard = 0;
        int cyc = 0;
        int last_rise = 0;
        logic prev;
        f = '1;
        period = 0;
        while (!sck_oe && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        prev = sck_out;
        while (got < 24 && guard < 20000) begin
            @(negedge clk);
            guard++;
            cyc++;
            if (sck_out && !prev) begin
                f[23-got] = sdo;
                if (got == 1) period = cyc - last_rise;
                last_rise = cyc;
                got++;
            end
            prev = sck_out;
        end
        while (sck_oe && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] f;
        logic last;
        int t0, t1, per;
        logic signed [DATA_W+1:0] v;
        logic signed [DATA_W+1:0] corner [10];
        void'($urandom(32'd1234));
        corner[0] = -(22'sd1 <<< 21);
        corner[1] = (22'sd1 <<< 21) - 1;
        corner[2] = -22'sd1;
        corner[3] = 22'sd0;
        corner[4] = 22'(FS - 1);
        corner[5] = 22'(FS);
        corner[6] = 22'(FS + FS / 8 - 1);
        corner[7] = 22'(FS + FS / 8);
        corner[8] = 22'(-(FS / 8));
        corner[9] = 22'(-(FS / 8) - 1);

        // power-up: cs held low, sck high -> internal mode (R12)
        sample_in = 22'sd12345;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset sdo converting", 32'(sdo), 1);
        check("R3 reset sdo_oe", 32'(sdo_oe), 1);
        check("R7 reset sck_oe", 32'(sck_oe), 0);
        wait_eoc(t0);
        sample_in = 22'sd777; // R9 change after capture
        read_int(f, per);
        check("R12 power-up internal frame", 32'(f), 32'(exp_frame(22'sd12345)));
        check("R7 internal sck period", 32'(per), DIV * TICKP);
        check("R5 sdo high after last bit", 32'(sdo), 1);
        t0 = tick_seen;
        sample_in = 22'sd999;
        wait_eoc(t1);
        check("R1 conversion ticks", 32'(t1 - t0), CONV);

        // abort in internal data phase (R6)
        @(negedge clk);
        cs_n = 1'b1;
        sck_in = 1'b0;
        sample_in = 22'sd4242;
        @(negedge clk);
        check("R3 sdo_oe low with cs high", 32'(sdo_oe), 0);
        check("R7 sck_oe low after abort", 32'(sck_oe), 0);
        repeat (5) sck_pulse(); // R3 ignored clocks
        repeat (CONV * TICKP + 40) @(negedge clk);
        check("R2 still deselected in sleep", 32'(sdo_oe), 0);
        cs_n = 1'b0;
        @(negedge clk);
        check("R2 ready on wake", 32'(sdo), 0);
        @(negedge clk);
        check("R7 external sck_oe", 32'(sck_oe), 0);
        read_ext(24, f, last);
        check("R6 abort restarted conversion frame", 32'(f), 32'(exp_frame(22'sd4242)));
        check("R5 sdo 1 after 24th fall", 32'(last), 1);
        sample_in = 22'sd31337;
        for (int k = 0; k < 3; k++) begin
            sck_pulse();
            check("R8 trailing clock reads 1", 32'(sdo), 1);
        end

        // partial external read then abort (R6)
        wait_eoc(t1);
        @(negedge clk);
        read_ext(5, f, last);
        check("R5 partial bits", 32'(f[23:18]), 32'(exp_frame(22'sd31337) >> 18));
        cs_n = 1'b1;
        @(negedge clk);
        check("R3 sdo_oe off on abort", 32'(sdo_oe), 0);
        cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 converting after abort", 32'(sdo), 1);

        // corners and random values in both modes
        for (int it = 0; it < 30; it++) begin
            logic im;
            v  = (it < 10) ? corner[it] : 22'($urandom);
            im = (it < 10) ? logic'(it % 2) : logic'($urandom_range(0, 1));
            cs_n = 1'b1;
            @(negedge clk);
            sck_in = im;
            @(negedge clk);
            sample_in = v;
            cs_n = 1'b0;
            wait_eoc(t1);
            sample_in = 22'($urandom); // R9
            if (im) begin
                read_int(f, per);
                check("R7 internal period", 32'(per), DIV * TICKP);
            end else begin
                @(negedge clk);
                read_ext(24, f, last);
            end
            if (it < 10) check("R11 R10 clamp corner frame", 32'(f), 32'(exp_frame(v)));
            else         check("R10 R9 random frame", 32'(f), 32'(exp_frame(v)));
            check("R5 sdo 1 after frame", 32'(sdo), 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule